// File: doc/BRIEF.md
# Nonvolatile Memory Command Sequence Controller

This block watches the host side of an asynchronous-style SRAM bus whose cycles have already been sampled into a synchronous clock domain. Each clock with `bus_vld` high is one bus cycle: a read when `bus_wr` is low and a write when it is high. Software requests nonvolatile operations by reading six fixed addresses in a fixed order. The first five addresses are a shared prefix. The sixth address selects STORE (copy SRAM into the nonvolatile cells), RECALL (copy the nonvolatile cells back into SRAM), automatic-store enable or automatic-store disable. Any write cycle in the train, or any read address that does not fit, breaks the train.

The controller launches STORE and RECALL transfers and times each one with a counter. While a transfer runs it holds a busy lockout, and during the lockout every host access is refused. A rising edge on a hardware store request also launches a STORE. A low-voltage flag blocks host writes and every externally requested STORE. When automatic store is enabled, the rising edge of that flag makes the block issue exactly one STORE itself.

Top module: `nvcmd_ctrl`

## Requirements
- R1: Six consecutive read cycles whose low `MATCH_W` address bits equal `KEY0`, `KEY1`, `KEY2`, `KEY3`, `KEY4` and then `KEY_STORE`, in that order, produce a one-cycle `store_go` pulse in the second clock cycle after the edge that samples the sixth read. `nv_busy` rises in the same cycle as the pulse.
- R2: A write cycle anywhere in the train returns the detector to idle. The reads that follow the write do not complete the command that was interrupted.
- R3: Address bits at or above `MATCH_W` take no part in the match.
- R4: A read that does not match the next expected entry restarts the match, and that same read is tested again as a possible first entry. A train whose prefix is out of order issues no command.
- R5: A train that ends in `KEY_RECALL` produces a one-cycle `recall_go` pulse. `nv_busy` then stays high for exactly `RECALL_CYC` cycles, and `op_done` pulses for one cycle straight after.
- R6: After `store_go`, `nv_busy` stays high for exactly `STORE_CYC` cycles, and a one-cycle `op_done` pulse follows in the first cycle with `nv_busy` low.
- R7: While `nv_busy` is high, `rd_ok` and `wr_ok` stay low. Bus cycles do not advance the detector, and hardware store edges are dropped.
- R8: While `low_volt` is high, `wr_ok` stays low and both the software STORE command and the hardware store request are inhibited. Reads are still granted.
- R9: A rising edge of `hw_store_req` while the block is idle and `low_volt` is low produces `store_go` in the next cycle.
- R10: `autostore_on` is 1 after reset. A train that ends in `KEY_AS_OFF` clears it and a train that ends in `KEY_AS_ON` sets it, in the same cycle in which a STORE would pulse. The value holds until the next such command.
- R11: A rising edge of `low_volt` while `autostore_on` is 1 issues exactly one STORE. If a transfer is running, that STORE follows in the cycle after its `op_done`. No further automatic STORE occurs until `low_volt` falls and rises again.
- R12: When a decoded STORE or RECALL command and a hardware store edge fall in the same cycle, the software command wins and the hardware edge is dropped. At most one of `store_go` and `recall_go` is high in any cycle.
- R13: After reset, `nv_busy`, `store_go`, `recall_go` and `op_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_vld | input | 1 | One sampled host bus cycle in this clock |
| bus_wr | input | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr | input | ADDR_W | Host address of the cycle |
| hw_store_req | input | 1 | Hardware store request, acted on at its rising edge |
| low_volt | input | 1 | Low supply voltage flag |
| rd_ok | output | 1 | Current read cycle is granted to the array |
| wr_ok | output | 1 | Current write cycle is granted to the array |
| store_go | output | 1 | One-cycle STORE launch pulse |
| recall_go | output | 1 | One-cycle RECALL launch pulse |
| nv_busy | output | 1 | Nonvolatile transfer in progress; bus locked out |
| op_done | output | 1 | One-cycle pulse at the end of a transfer |
| autostore_on | output | 1 | Automatic store on low voltage is enabled |

## Verification
A software RECALL command and a hardware store edge can be decoded in the same clock. The bench raises `hw_store_req` in exactly the cycle after the sixth RECALL read. It expects `recall_go` without `store_go`, and it expects no STORE once the RECALL has finished. A low-voltage edge can also arrive while a RECALL is running. The bench raises `low_volt` in mid-transfer and expects the deferred automatic STORE in the cycle right after `op_done`.

// File: rtl/nvcmd_pkg.sv
package nvcmd_pkg;

    localparam int SEQ_LEN = 6;
    localparam int PFX_LEN = SEQ_LEN - 1;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STORE,
        CMD_RECALL,
        CMD_AS_ON,
        CMD_AS_OFF
    } nv_cmd_e;

endpackage

// File: rtl/nvcmd_seq_det.sv
module nvcmd_seq_det
    import nvcmd_pkg::*;
#(
    parameter int                ADDR_W     = 18,
    parameter int                MATCH_W    = 13,
    parameter logic [MATCH_W-1:0] KEY0       = 13'h1A5C,
    parameter logic [MATCH_W-1:0] KEY1       = 13'h05A3,
    parameter logic [MATCH_W-1:0] KEY2       = 13'h0F0F,
    parameter logic [MATCH_W-1:0] KEY3       = 13'h10F0,
    parameter logic [MATCH_W-1:0] KEY4       = 13'h0333,
    parameter logic [MATCH_W-1:0] KEY_STORE  = 13'h1CCC,
    parameter logic [MATCH_W-1:0] KEY_RECALL = 13'h0E71,
    parameter logic [MATCH_W-1:0] KEY_AS_ON  = 13'h1B2D,
    parameter logic [MATCH_W-1:0] KEY_AS_OFF = 13'h04D2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_vld,
    input  logic              cyc_wr,
    input  logic [ADDR_W-1:0] cyc_addr,
    input  logic              hold,
    output logic              cmd_vld,
    output nv_cmd_e           cmd
);

    localparam int IDX_W   = $clog2(SEQ_LEN);
    localparam int HIT_LEN = 2 ** IDX_W;
    localparam logic [MATCH_W-1:0] PFX [PFX_LEN] = '{KEY0, KEY1, KEY2, KEY3, KEY4};

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             vld;
        nv_cmd_e          cmd;
    } det_t;

    det_t s_d, s_q;

    logic [MATCH_W-1:0] key;
    logic [HIT_LEN-1:0] hit;
    nv_cmd_e            tail;

    assign key = cyc_addr[MATCH_W-1:0];

    // one comparator per prefix slot; unused slots never match
    for (genvar i = 0; i < HIT_LEN; i++) begin : g_hit
        if (i < PFX_LEN) begin : g_cmp
            assign hit[i] = (key == PFX[i]);
        end else begin : g_pad
            assign hit[i] = 1'b0;
        end
    end

    always_comb begin
        if (key == KEY_STORE)       tail = CMD_STORE;
        else if (key == KEY_RECALL) tail = CMD_RECALL;
        else if (key == KEY_AS_ON)  tail = CMD_AS_ON;
        else if (key == KEY_AS_OFF) tail = CMD_AS_OFF;
        else                        tail = CMD_NONE;
    end

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        s_d.cmd = CMD_NONE;
        if (hold) begin
            s_d.idx = '0;
        end else if (cyc_vld) begin
            if (cyc_wr) begin
                s_d.idx = '0;
            end else if (s_q.idx == IDX_W'(PFX_LEN)) begin
                if (tail != CMD_NONE) begin
                    s_d.vld = 1'b1;
                    s_d.cmd = tail;
                    s_d.idx = '0;
                end else begin
                    s_d.idx = hit[0] ? IDX_W'(1) : '0;
                end
            end else if (hit[s_q.idx]) begin
                s_d.idx = s_q.idx + IDX_W'(1);
            end else begin
                // a broken train may be the start of a fresh one
                s_d.idx = hit[0] ? IDX_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{idx: '0, vld: 1'b0, cmd: CMD_NONE};
        end else begin
            s_q <= s_d;
        end
    end

    assign cmd_vld = s_q.vld;
    assign cmd     = s_q.cmd;

endmodule

// File: rtl/nvcmd_op_timer.sv
module nvcmd_op_timer #(
    parameter int STORE_CYC  = 40,
    parameter int RECALL_CYC = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go_store,
    input  logic go_recall,
    output logic busy,
    output logic done
);

    localparam int MAX_CYC = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             done;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d      = t_q;
        t_d.done = 1'b0;
        if (t_q.busy) begin
            if (t_q.cnt == '0) begin
                t_d.busy = 1'b0;
                t_d.done = 1'b1;
            end else begin
                t_d.cnt = t_q.cnt - CNT_W'(1);
            end
        end else if (go_store) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(STORE_CYC - 1);
        end else if (go_recall) begin
            t_d.busy = 1'b1;
            t_d.cnt  = CNT_W'(RECALL_CYC - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign busy = t_q.busy;
    assign done = t_q.done;

endmodule

// File: rtl/nvcmd_ctrl.sv
module nvcmd_ctrl
    import nvcmd_pkg::*;
#(
    parameter int                ADDR_W     = 18,
    parameter int                MATCH_W    = 13,
    parameter int                STORE_CYC  = 40,
    parameter int                RECALL_CYC = 24,
    parameter logic [MATCH_W-1:0] KEY0       = 13'h1A5C,
    parameter logic [MATCH_W-1:0] KEY1       = 13'h05A3,
    parameter logic [MATCH_W-1:0] KEY2       = 13'h0F0F,
    parameter logic [MATCH_W-1:0] KEY3       = 13'h10F0,
    parameter logic [MATCH_W-1:0] KEY4       = 13'h0333,
    parameter logic [MATCH_W-1:0] KEY_STORE  = 13'h1CCC,
    parameter logic [MATCH_W-1:0] KEY_RECALL = 13'h0E71,
    parameter logic [MATCH_W-1:0] KEY_AS_ON  = 13'h1B2D,
    parameter logic [MATCH_W-1:0] KEY_AS_OFF = 13'h04D2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_vld,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              hw_store_req,
    input  logic              low_volt,
    output logic              rd_ok,
    output logic              wr_ok,
    output logic              store_go,
    output logic              recall_go,
    output logic              nv_busy,
    output logic              op_done,
    output logic              autostore_on
);

    typedef struct packed {
        logic as_en;
        logic as_pend;
        logic hw_q;
        logic lv_q;
        logic store_go;
        logic recall_go;
    } ctl_t;

    ctl_t    c_d, c_q;
    logic    cmd_vld;
    nv_cmd_e cmd;
    logic    busy;
    logic    done;
    logic    start_store, start_recall;
    logic    hw_rise, lv_rise, as_req;

    nvcmd_seq_det #(
        .ADDR_W    (ADDR_W),
        .MATCH_W   (MATCH_W),
        .KEY0      (KEY0),
        .KEY1      (KEY1),
        .KEY2      (KEY2),
        .KEY3      (KEY3),
        .KEY4      (KEY4),
        .KEY_STORE (KEY_STORE),
        .KEY_RECALL(KEY_RECALL),
        .KEY_AS_ON (KEY_AS_ON),
        .KEY_AS_OFF(KEY_AS_OFF)
    ) u_det (
        .clk     (clk),
        .rst_n   (rst_n),
        .cyc_vld (bus_vld),
        .cyc_wr  (bus_wr),
        .cyc_addr(bus_addr),
        .hold    (busy),
        .cmd_vld (cmd_vld),
        .cmd     (cmd)
    );

    nvcmd_op_timer #(
        .STORE_CYC (STORE_CYC),
        .RECALL_CYC(RECALL_CYC)
    ) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_store (start_store),
        .go_recall(start_recall),
        .busy     (busy),
        .done     (done)
    );

    assign hw_rise = hw_store_req & ~c_q.hw_q;
    assign lv_rise = low_volt & ~c_q.lv_q;
    assign as_req  = c_q.as_pend | (lv_rise & c_q.as_en);

    always_comb begin
        c_d           = c_q;
        c_d.hw_q      = hw_store_req;
        c_d.lv_q      = low_volt;
        start_store   = 1'b0;
        start_recall  = 1'b0;

        if (cmd_vld && cmd == CMD_AS_ON)  c_d.as_en = 1'b1;
        if (cmd_vld && cmd == CMD_AS_OFF) c_d.as_en = 1'b0;

        // priority: automatic store, software command, hardware request
        if (!busy) begin
            if (as_req) begin
                start_store = 1'b1;
                c_d.as_pend = 1'b0;
            end else if (cmd_vld && cmd == CMD_STORE && !low_volt) begin
                start_store = 1'b1;
            end else if (cmd_vld && cmd == CMD_RECALL) begin
                start_recall = 1'b1;
            end else if (hw_rise && !low_volt) begin
                start_store = 1'b1;
            end
        end else if (as_req) begin
            c_d.as_pend = 1'b1;
        end

        if (!low_volt) c_d.as_pend = 1'b0;

        c_d.store_go  = start_store;
        c_d.recall_go = start_recall;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{as_en: 1'b1, as_pend: 1'b0, hw_q: 1'b0, lv_q: 1'b0,
                     store_go: 1'b0, recall_go: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign rd_ok        = bus_vld & ~bus_wr & ~busy;
    assign wr_ok        = bus_vld & bus_wr & ~busy & ~low_volt;
    assign store_go     = c_q.store_go;
    assign recall_go    = c_q.recall_go;
    assign nv_busy      = busy;
    assign op_done      = done;
    assign autostore_on = c_q.as_en;

endmodule

// File: rtl/nvcmd_ctrl_chk.sv
module nvcmd_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_vld,
    input logic bus_wr,
    input logic low_volt,
    input logic rd_ok,
    input logic wr_ok,
    input logic store_go,
    input logic recall_go,
    input logic nv_busy,
    input logic op_done,
    input logic autostore_on
);

    p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        nv_busy |-> (!rd_ok && !wr_ok));

    p_lv_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        low_volt |-> !wr_ok);

    p_go_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({store_go, recall_go}));

    p_go_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_go || recall_go) |-> (nv_busy && !$past(nv_busy)));

    p_done_after_r6: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> (!nv_busy && $past(nv_busy)));

    p_fall_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(nv_busy) |-> op_done);

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(autostore_on) || $past(bus_vld && !bus_wr, 2));

endmodule

bind nvcmd_ctrl nvcmd_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_vld     (bus_vld),
    .bus_wr      (bus_wr),
    .low_volt    (low_volt),
    .rd_ok       (rd_ok),
    .wr_ok       (wr_ok),
    .store_go    (store_go),
    .recall_go   (recall_go),
    .nv_busy     (nv_busy),
    .op_done     (op_done),
    .autostore_on(autostore_on)
);

// File: tb/nvcmd_ctrl_bench.sv
module nvcmd_ctrl_bench;

    localparam int ADDR_W = 18;
    localparam int MW     = 13;
    localparam int SCYC   = 40;
    localparam int RCYC   = 24;
    localparam logic [MW-1:0] K0 = 13'h1A5C, K1 = 13'h05A3, K2 = 13'h0F0F,
                              K3 = 13'h10F0, K4 = 13'h0333;
    localparam logic [MW-1:0] KS = 13'h1CCC, KR = 13'h0E71,
                              KON = 13'h1B2D, KOFF = 13'h04D2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_vld = 1'b0, bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic hw_store_req = 1'b0, low_volt = 1'b0;
    logic rd_ok, wr_ok, store_go, recall_go, nv_busy, op_done, autostore_on;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    nvcmd_ctrl #(
        .ADDR_W(ADDR_W), .MATCH_W(MW), .STORE_CYC(SCYC), .RECALL_CYC(RCYC),
        .KEY0(K0), .KEY1(K1), .KEY2(K2), .KEY3(K3), .KEY4(K4),
        .KEY_STORE(KS), .KEY_RECALL(KR), .KEY_AS_ON(KON), .KEY_AS_OFF(KOFF)
    ) u_nvcmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .hw_store_req(hw_store_req), .low_volt(low_volt),
        .rd_ok(rd_ok), .wr_ok(wr_ok), .store_go(store_go), .recall_go(recall_go),
        .nv_busy(nv_busy), .op_done(op_done), .autostore_on(autostore_on)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [ADDR_W-1:0] a);
        bus_vld  = 1'b1;
        bus_wr   = wr;
        bus_addr = a;
        @(negedge clk);
        bus_vld  = 1'b0;
        bus_wr   = 1'b0;
    endtask

    task automatic rd(input logic [MW-1:0] k, input logic [ADDR_W-MW-1:0] up);
        cyc(1'b0, {up, k});
    endtask

    task automatic train(input logic [MW-1:0] last);
        rd(K0, '0); rd(K1, '0); rd(K2, '0); rd(K3, '0); rd(K4, '0); rd(last, '0);
    endtask

    task automatic count_go(input int n, output int c);
        c = 0;
        repeat (n) begin
            @(negedge clk);
            if (store_go || recall_go) c++;
        end
    endtask

    task automatic wait_idle();
        while (nv_busy || op_done) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R13 busy", nv_busy, 0);
        chk("R13 store_go", store_go, 0);
        chk("R13 recall_go", recall_go, 0);
        chk("R13 op_done", op_done, 0);
        chk("R10 reset autostore_on", autostore_on, 1);
    endtask

    task automatic t_store();
        train(KS);
        chk("R1 no go before second edge", store_go, 0);
        @(negedge clk);
        chk("R1 store_go", store_go, 1);
        chk("R1 busy with go", nv_busy, 1);
        repeat (SCYC - 1) begin
            @(negedge clk);
            if (!nv_busy) chk("R6 busy held", nv_busy, 1);
        end
        @(negedge clk);
        chk("R6 busy low after STORE_CYC", nv_busy, 0);
        chk("R6 done pulse", op_done, 1);
        @(negedge clk);
        chk("R6 done one cycle", op_done, 0);
    endtask

    task automatic t_recall();
        train(KR);
        @(negedge clk);
        chk("R5 recall_go", recall_go, 1);
        chk("R5 store_go quiet", store_go, 0);
        repeat (RCYC - 1) begin
            @(negedge clk);
            if (!nv_busy) chk("R5 busy held", nv_busy, 1);
        end
        @(negedge clk);
        chk("R5 busy low after RECALL_CYC", nv_busy, 0);
        chk("R5 done pulse", op_done, 1);
    endtask

    task automatic t_upper();
        rd(K0, 5'h1F); rd(K1, 5'h0A); rd(K2, 5'h15);
        rd(K3, 5'h01); rd(K4, 5'h10); rd(KS, 5'h1E);
        @(negedge clk);
        chk("R3 upper bits ignored", store_go, 1);
        wait_idle();
    endtask

    task automatic t_write_abort();
        int c;
        rd(K0, '0); rd(K1, '0); rd(K2, '0);
        cyc(1'b1, {5'h0, K3});
        rd(K3, '0); rd(K4, '0); rd(KS, '0);
        count_go(8, c);
        chk("R2 write aborts train", c, 0);
    endtask

    task automatic t_order();
        int c;
        rd(K0, '0); rd(K2, '0); rd(K1, '0); rd(K3, '0); rd(K4, '0); rd(KS, '0);
        count_go(8, c);
        chk("R4 out of order ignored", c, 0);
        rd(K0, '0); rd(K1, '0); rd(K0, '0); rd(K1, '0);
        rd(K2, '0); rd(K3, '0); rd(K4, '0); rd(KS, '0);
        @(negedge clk);
        chk("R4 restart on mismatched first entry", store_go, 1);
        wait_idle();
    endtask

    task automatic t_lockout();
        int c;
        bus_vld = 1'b1; bus_wr = 1'b0; #1;
        chk("R7 read granted when idle", rd_ok, 1);
        bus_vld = 1'b0; @(negedge clk);
        train(KR);
        @(negedge clk);
        chk("R7 recall started", recall_go, 1);
        bus_vld = 1'b1; bus_wr = 1'b1; #1;
        chk("R7 write blocked while busy", wr_ok, 0);
        bus_wr = 1'b0; #1;
        chk("R7 read blocked while busy", rd_ok, 0);
        bus_vld = 1'b0;
        @(negedge clk);
        train(KS);
        hw_store_req = 1'b1; @(negedge clk); hw_store_req = 1'b0;
        wait_idle();
        count_go(10, c);
        chk("R7 cycles during busy ignored", c, 0);
    endtask

    task automatic t_hw();
        hw_store_req = 1'b1;
        @(negedge clk);
        chk("R9 hw store go", store_go, 1);
        chk("R9 hw busy", nv_busy, 1);
        hw_store_req = 1'b0;
        wait_idle();
    endtask

    task automatic t_lowv();
        int c;
        low_volt = 1'b1;
        @(negedge clk);
        chk("R11 autostore on lv rise", store_go, 1);
        wait_idle();
        train(KS);
        count_go(6, c);
        chk("R8 sw store inhibited", c, 0);
        hw_store_req = 1'b1;
        count_go(4, c);
        hw_store_req = 1'b0;
        chk("R8 hw store inhibited", c, 0);
        bus_vld = 1'b1; bus_wr = 1'b1; #1;
        chk("R8 write blocked on low voltage", wr_ok, 0);
        bus_wr = 1'b0; #1;
        chk("R8 read allowed on low voltage", rd_ok, 1);
        bus_vld = 1'b0;
        count_go(6, c);
        chk("R11 single autostore per rise", c, 0);
        low_volt = 1'b0;
        @(negedge clk);
        low_volt = 1'b1;
        @(negedge clk);
        chk("R11 second rise stores again", store_go, 1);
        wait_idle();
        low_volt = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_mode();
        int c;
        train(KOFF);
        @(negedge clk);
        chk("R10 disable command", autostore_on, 0);
        low_volt = 1'b1;
        count_go(8, c);
        chk("R10 no autostore when disabled", c, 0);
        low_volt = 1'b0;
        @(negedge clk);
        train(KON);
        @(negedge clk);
        chk("R10 enable command", autostore_on, 1);
        count_go(4, c);
        chk("R10 mode change launches nothing", c, 0);
    endtask

    task automatic t_defer();
        train(KR);
        @(negedge clk);
        chk("R11 recall before deferral", recall_go, 1);
        repeat (3) @(negedge clk);
        low_volt = 1'b1;
        @(negedge clk);
        chk("R11 no store while busy", store_go, 0);
        while (!op_done) @(negedge clk);
        @(negedge clk);
        chk("R11 deferred store after done", store_go, 1);
        wait_idle();
        low_volt = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_collide();
        int c;
        train(KR);
        hw_store_req = 1'b1;
        @(negedge clk);
        chk("R12 recall wins", recall_go, 1);
        chk("R12 hw store dropped", store_go, 0);
        hw_store_req = 1'b0;
        wait_idle();
        count_go(6, c);
        chk("R12 no late store", c, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_store();
        t_recall();
        t_upper();
        t_write_abort();
        t_order();
        t_lockout();
        t_hw();
        t_lowv();
        t_mode();
        t_defer();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R13 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule